// File: doc/BRIEF.md
# Window Watchdog with Hysteresis

This block watches a periodic trigger from a host processor and decides whether the host is still running normally. It runs on a slow time-base tick clock. It measures the time between successive rising edges of the trigger in ticks and judges each interval against a period window. An interval inside the window counts as good. An interval that is too short or too long counts as bad.

A saturating score from 0 to 3 accumulates the verdicts. Good verdicts raise the score and bad ones lower it. A flag with set/reset hysteresis derives the health output from the score. While the output reports healthy, the window widens by one tick on each side, so a trigger running right at a limit does not make the verdict flicker. A trigger that stops altogether drops the output at once, without waiting for three bad verdicts.

The reset input comes from the supply monitor. It puts the block in its initial failed state with a score of zero. The host is expected to trigger at one hundredth of the tick rate, which gives a nominal interval of 100 ticks.

Top module: `trig_window_wdog`

## Requirements
- R1: Each detected rising edge of `trig_i` restarts the interval measurement. The interval judged at an edge is the number of ticks since the previous detected edge. For the first edge after reset, it is the number of ticks since reset release.
- R2: The score saturates at 0 and 3. A good verdict adds 1 and a bad verdict subtracts 1. Without a detected edge or a dropout the score holds.
- R3: `wd_ok_o` goes to 1 when the score reaches 3 and to 0 when the score reaches 0; otherwise it holds its value. A verdict reaches `wd_ok_o` on the third rising tick edge after `trig_i` is first sampled high.
- R4: While `wd_ok_o` is 0, an interval N is good only when 80 <= N <= 169.
- R5: While `wd_ok_o` is 1, an interval N is good only when 79 <= N <= 170.
- R6: If 250 ticks pass without a detected edge, the score becomes 0 and `wd_ok_o` becomes 0 on that tick.
- R7: A trigger pulse that stays high for 2 ticks is detected as an edge.
- R8: A steady trigger at the nominal 100-tick interval raises `wd_ok_o` on the third detected edge and keeps it high.
- R9: An active-low `rst_ni` clears the score and `wd_ok_o` at once, without waiting for a clock edge.
- R10: The interval count saturates at 250 and never wraps. A gap longer than 250 ticks is therefore always judged bad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Time-base tick clock |
| rst_ni | input | 1 | Asynchronous active-low reset from the supply monitor |
| trig_i | input | 1 | Asynchronous periodic trigger from the host |
| wd_ok_o | output | 1 | 1 = watchdog healthy, 0 = failed |

## Verification
A trigger edge driven by the bench becomes a verdict on `wd_ok_o` three tick edges later: two synchroniser stages and the score register. Every trigger pulse is held for at least 2 ticks, and each check samples on a falling edge at least half a tick after that update.

Window limits are checked by surrounding the interval under test with verdicts whose outcome is known. A single good or bad verdict then shows up as a difference in `wd_ok_o`. The dropout takes effect 250 ticks after the last score update, so the bench samples at 244 and at 259 ticks after the trigger, which keeps both samples clear of the exact drop tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Outcome of one interval measurement, valid only on a detected edge.
   typedef enum logic [1:0] {
      VERD_NONE = 2'd0,
      VERD_GOOD = 2'd1,
      VERD_BAD  = 2'd2
   } verdict_e;

endpackage

// File: rtl/wdog_trig_sync.sv
module wdog_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   output logic rise_o
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], trig_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/wdog_interval.sv
module wdog_interval
   import wdog_pkg::*;
#(
   parameter int WIN_LO   = 80,
   parameter int WIN_HI   = 169,
   parameter int HYST     = 1,
   parameter int DROP_LIM = 250,
   parameter int IVAL_W   = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rise_i,
   input  logic              ok_i,
   output verdict_e          verdict_o,
   output logic              drop_o,
   output logic [IVAL_W-1:0] ival_o
);

   localparam logic [IVAL_W-1:0] LIM  = IVAL_W'(DROP_LIM);
   localparam logic [IVAL_W-1:0] ONE  = IVAL_W'(1);

   logic [IVAL_W-1:0] ival_q;
   logic [IVAL_W-1:0] lo_lim;
   logic [IVAL_W-1:0] hi_lim;
   logic              in_win;

   // Saturating tick count since the last detected edge.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         ival_q <= '0;
      else if (rise_i)
         ival_q <= ONE;
      else if (ival_q != LIM)
         ival_q <= ival_q + ONE;
   end

   // Window limits: widened by HYST ticks each side while healthy.
   if (HYST > 0) begin : g_hyst
      assign lo_lim = ok_i ? IVAL_W'(WIN_LO - HYST) : IVAL_W'(WIN_LO);
      assign hi_lim = ok_i ? IVAL_W'(WIN_HI + HYST) : IVAL_W'(WIN_HI);
   end else begin : g_fixed
      assign lo_lim = IVAL_W'(WIN_LO);
      assign hi_lim = IVAL_W'(WIN_HI);
   end

   assign in_win    = (ival_q >= lo_lim) && (ival_q <= hi_lim);
   assign verdict_o = !rise_i ? VERD_NONE : (in_win ? VERD_GOOD : VERD_BAD);
   assign drop_o    = !rise_i && (ival_q == LIM);
   assign ival_o    = ival_q;

endmodule

// File: rtl/wdog_health.sv
module wdog_health
   import wdog_pkg::*;
#(
   parameter int CNT_MAX = 3,
   parameter int CNT_W   = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  verdict_e         verdict_i,
   input  logic             drop_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ok_o
);

   localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);
   localparam logic [CNT_W-1:0] UNIT = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             ok_q, ok_d;

   always_comb begin
      cnt_d = cnt_q;
      if (drop_i)
         cnt_d = '0;
      else if (verdict_i == VERD_GOOD && cnt_q != TOP)
         cnt_d = cnt_q + UNIT;
      else if (verdict_i == VERD_BAD && cnt_q != '0)
         cnt_d = cnt_q - UNIT;
   end

   always_comb begin
      ok_d = ok_q;
      if (cnt_d == TOP)
         ok_d = 1'b1;
      else if (cnt_d == '0)
         ok_d = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         ok_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         ok_q  <= ok_d;
      end
   end

   assign cnt_o = cnt_q;
   assign ok_o  = ok_q;

endmodule

// File: rtl/trig_window_wdog.sv
module trig_window_wdog
   import wdog_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WIN_LO      = 80,
   parameter int WIN_HI      = 169,
   parameter int HYST        = 1,
   parameter int DROP_LIM    = 250,
   parameter int CNT_MAX     = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   output logic wd_ok_o
);

   localparam int IVAL_W = $clog2(DROP_LIM + 1);
   localparam int CNT_W  = $clog2(CNT_MAX + 1);

   // Elaboration-time parameter checks.
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (HYST < 0 || WIN_LO <= HYST) begin : g_chk_lo
      $error("WIN_LO must exceed HYST, HYST non-negative");
   end
   if (WIN_HI < WIN_LO || WIN_HI + HYST >= DROP_LIM) begin : g_chk_hi
      $error("window must sit below the dropout limit");
   end
   if (CNT_MAX < 1) begin : g_chk_cnt
      $error("CNT_MAX must be at least 1");
   end

   logic              rise;
   logic              drop;
   verdict_e          verdict;
   logic [IVAL_W-1:0] ival;
   logic [CNT_W-1:0]  cnt;

   wdog_trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (trig_i),
      .rise_o (rise)
   );

   wdog_interval #(
      .WIN_LO   (WIN_LO),
      .WIN_HI   (WIN_HI),
      .HYST     (HYST),
      .DROP_LIM (DROP_LIM),
      .IVAL_W   (IVAL_W)
   ) ival_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_i    (rise),
      .ok_i      (wd_ok_o),
      .verdict_o (verdict),
      .drop_o    (drop),
      .ival_o    (ival)
   );

   wdog_health #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) health_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .verdict_i (verdict),
      .drop_i    (drop),
      .cnt_o     (cnt),
      .ok_o      (wd_ok_o)
   );

endmodule

// File: rtl/trig_window_wdog_chk.sv
module trig_window_wdog_chk #(
   parameter int CNT_MAX  = 3,
   parameter int DROP_LIM = 250,
   parameter int IVAL_W   = $clog2(DROP_LIM + 1),
   parameter int CNT_W    = $clog2(CNT_MAX + 1)
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              rise,
   input logic              drop,
   input logic              ok,
   input logic [CNT_W-1:0]  cnt,
   input logic [IVAL_W-1:0] ival
);

   // R2: the score never leaves 0..CNT_MAX
   a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt <= CNT_W'(CNT_MAX));

   // R2: no edge and no dropout leaves the score unchanged
   a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rise && !drop) |=> $stable(cnt));

   // R3: a full score means healthy
   a_r3_ok_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt == CNT_W'(CNT_MAX)) |-> ok);

   // R3: an empty score means failed
   a_r3_low_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt == '0) |-> !ok);

   // R1: a detected edge restarts the interval count
   a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise |=> (ival == IVAL_W'(1)));

   // R6: a dropout empties the score and clears the flag
   a_r6_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop |=> (cnt == '0 && !ok));

   // R10: the interval count never passes the dropout limit
   a_r10_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ival <= IVAL_W'(DROP_LIM));

endmodule

bind trig_window_wdog trig_window_wdog_chk #(
   .CNT_MAX  (CNT_MAX),
   .DROP_LIM (DROP_LIM)
) chk_i (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .rise   (rise),
   .drop   (drop),
   .ok     (wd_ok_o),
   .cnt    (cnt),
   .ival   (ival)
);

// File: tb/trig_window_wdog_tb_top.sv
module trig_window_wdog_tb_top;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic trig  = 1'b0;
   logic ok;
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   trig_window_wdog dut_i (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .trig_i  (trig),
      .wd_ok_o (ok)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: wd_ok_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // Rising edge n ticks after the previous one, held high w ticks.
   task automatic gap_w(input int n, input int w);
      repeat (n - w) @(negedge clk);
      trig = 1'b1;
      repeat (w) @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic gap(input int n);
      gap_w(n, 4);
   endtask

   // Reset, then one edge about 100 ticks later: score 1, flag low.
   task automatic restart();
      @(negedge clk);
      rst_n = 1'b0;
      trig  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      gap(100);
   endtask

   // Score 3, flag high.
   task automatic go_ok();
      restart();
      gap(100);
      gap(100);
   endtask

   task automatic t_reset_state();
      repeat (2) @(negedge clk);
      check("R9 reset state", ok, 1'b0);
   endtask

   task automatic t_nominal();
      restart();
      check("R8 one edge", ok, 1'b0);
      gap(100);
      check("R8 two edges", ok, 1'b0);
      gap(100);
      check("R8 third edge sets", ok, 1'b1);
      for (int i = 0; i < 10; i++) gap(100);
      check("R1 R8 steady trigger keeps healthy", ok, 1'b1);
   endtask

   task automatic t_low_win(input int n, input logic exp);
      restart();
      gap(n);
      gap(100);
      check($sformatf("R4 interval %0d while failed", n), ok, exp);
   endtask

   task automatic t_high_win(input int n, input logic exp);
      go_ok();
      gap(n);
      gap(40);
      gap(40);
      check($sformatf("R5 interval %0d while healthy", n), ok, exp);
   endtask

   task automatic t_hysteresis();
      go_ok();
      gap(40);
      check("R3 first bad holds flag", ok, 1'b1);
      gap(40);
      check("R3 second bad holds flag", ok, 1'b1);
      gap(40);
      check("R3 third bad clears flag", ok, 1'b0);
   endtask

   task automatic t_sat_top();
      go_ok();
      for (int i = 0; i < 4; i++) gap(100);
      gap(40);
      gap(40);
      check("R2 score capped at 3", ok, 1'b1);
      gap(40);
      check("R2 capped score empties after 3 bad", ok, 1'b0);
   endtask

   task automatic t_sat_bottom();
      restart();
      for (int i = 0; i < 5; i++) gap(40);
      check("R2 score floors at 0", ok, 1'b0);
      gap(100);
      gap(100);
      check("R2 two good from floor", ok, 1'b0);
      gap(100);
      check("R2 three good from floor", ok, 1'b1);
   endtask

   task automatic t_dropout();
      go_ok();
      repeat (240) @(negedge clk);
      check("R6 before dropout limit", ok, 1'b1);
      repeat (15) @(negedge clk);
      check("R6 after dropout limit", ok, 1'b0);
      gap(100);
      gap(100);
      gap(100);
      check("R6 score emptied by dropout", ok, 1'b0);
      gap(100);
      check("R6 recovery after three good", ok, 1'b1);
   endtask

   task automatic t_no_wrap();
      restart();
      gap(100);
      gap(356);
      gap(100);
      gap(100);
      check("R10 long gap judged bad", ok, 1'b0);
   endtask

   task automatic t_short_pulse();
      restart();
      gap_w(100, 2);
      gap_w(100, 2);
      repeat (3) @(negedge clk);
      check("R7 two-tick pulses detected", ok, 1'b1);
   endtask

   task automatic t_reset_mid();
      go_ok();
      check("R9 healthy before reset", ok, 1'b1);
      rst_n = 1'b0;
      #1;
      check("R9 asynchronous clear", ok, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      gap(100);
      gap(100);
      check("R9 score cleared by reset", ok, 1'b0);
   endtask

   initial begin
      t_reset_state();
      t_nominal();
      t_low_win(79, 1'b0);
      t_low_win(80, 1'b1);
      t_low_win(169, 1'b1);
      t_low_win(170, 1'b0);
      t_high_win(78, 1'b0);
      t_high_win(79, 1'b1);
      t_high_win(170, 1'b1);
      t_high_win(171, 1'b0);
      t_hysteresis();
      t_sat_top();
      t_sat_bottom();
      t_dropout();
      t_no_wrap();
      t_short_pulse();
      t_reset_mid();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule